// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block collects level-sensitive interrupt requests from up to 96 sources (128 by parameter), grouped into banks of 32. Each source can be masked through a per-bank mask register, a clear alias and a set alias. Each source also carries a programmable priority. The controller picks the best unmasked request that passes a priority threshold, latches its number into an active-number register and raises one interrupt line to the processor.

The processor reads the active number and services that source. It then writes the acknowledge bit, which releases the controller to present the next request. A soft-reset request returns every register to its power-up value. A status bit reports when that reset has completed. Software reaches all state through a 32-bit single-cycle register port. Read data is registered.

Top module: `prio_intc`

## Requirements
- R1: After reset, every mask bit is 1, the threshold reads 0xFF, the active number reads 0 and `irq` is low.
- R2: Bank b has its mask register at 0x84+0x20*b, a clear alias at 0x88+0x20*b and a set alias at 0x8C+0x20*b. A 1 written to the clear alias unmasks that line, and a 1 written to the set alias masks it. Bits written as 0 leave the mask unchanged. The mask register itself can be written directly and read back.
- R3: The register at 0x98+0x20*b reads the asserted sources of bank b that are not masked (source AND NOT mask).
- R4: The priority of each line is bits 7:2 of its level register, where 0 is the most urgent. Among eligible lines the smallest priority value wins, and equal values go to the lower line number. The number of the latched line reads in bits 6:0 of the register at 0x40.
- R5: The threshold register at 0x68 admits only lines whose priority is numerically below it. The value 0xFF admits every line.
- R6: `irq` rises at the first clock edge at which an eligible line exists while no interrupt is active. From then on, `irq` and the active number stay frozen until acknowledged, even if sources drop or a more urgent line appears.
- R7: A write with bit 0 set to the control register at 0x48 drops `irq` at that edge, and the next edge may latch a new winner. A write there with bit 0 clear has no effect.
- R8: A write with bit 1 set to the configuration register at 0x10 starts a soft reset. Bit 0 of the status register at 0x14 reads 0 for RST_CYC cycles after a hard or soft reset and then reads 1. All registers return to their R1 values, and writes during that window are ignored.
- R9: Configuration bit 0 (auto-idle enable), protection register 0x4C bit 0 and idle register 0x50 bits 1:0 store and read back. All other bits of these registers read 0.
- R10: The revision register at 0x00 reads the major version in bits 7:4 and the minor version in bits 3:0.
- R11: Line n has its level register at 0x100+4*n. It reads back the priority in bits 7:2, and all other bits read 0.
- R12: Read data appears on `bus_rdata` one clock edge after the address is presented. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Register byte address |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| src_lvl | input | NUM_SRC | Level-sensitive interrupt sources |
| irq | output | 1 | Interrupt request to the processor |

## Verification
The bench targets these corner cases:

- **Tie on priority.** A design that resolved ties toward the higher line number would report line 5 instead of line 2, or line 70 instead of line 40.
- **Freeze while active.** The bench drops the active source and raises more urgent ones while an interrupt is active. A design that tracked live would change the active number or drop `irq` before the acknowledge.
- **Threshold boundary.** The bench sets the threshold exactly equal to a pending priority. A design using less-or-equal would raise `irq` when it must stay low.
- **Soft reset.** The bench writes during the soft-reset window and checks the alias writes that carry zero bits. A faulty design would keep the stray threshold write or alter untouched mask bits.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
  localparam int REG_AW = 12;
  localparam int REG_DW = 32;
  localparam int BANK_W = 32;
  localparam int THR_W  = 8;

  localparam logic [REG_AW-1:0] OFS_REV  = 12'h000;
  localparam logic [REG_AW-1:0] OFS_CFG  = 12'h010;
  localparam logic [REG_AW-1:0] OFS_STAT = 12'h014;
  localparam logic [REG_AW-1:0] OFS_ACT  = 12'h040;
  localparam logic [REG_AW-1:0] OFS_CTRL = 12'h048;
  localparam logic [REG_AW-1:0] OFS_PROT = 12'h04C;
  localparam logic [REG_AW-1:0] OFS_IDLE = 12'h050;
  localparam logic [REG_AW-1:0] OFS_THR  = 12'h068;
  localparam logic [REG_AW-1:0] OFS_MASK = 12'h084;
  localparam logic [REG_AW-1:0] OFS_MCLR = 12'h088;
  localparam logic [REG_AW-1:0] OFS_MSET = 12'h08C;
  localparam logic [REG_AW-1:0] OFS_PEND = 12'h098;
  localparam logic [REG_AW-1:0] OFS_LVL  = 12'h100;
  localparam logic [REG_AW-1:0] BANK_STEP = 12'h020;

  // per-bank register address: base plus one stride per bank
  function automatic logic [REG_AW-1:0] bank_ofs(input logic [REG_AW-1:0] base, input int b);
    return base + REG_AW'(b) * BANK_STEP;
  endfunction
endpackage

// File: rtl/intc_mask_bank.sv
module intc_mask_bank
  import prio_intc_pkg::*;
#(
  parameter int W = BANK_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         wr_mask,
  input  logic         wr_clr,
  input  logic         wr_set,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] src,
  output logic [W-1:0] mask,
  output logic [W-1:0] pend
);
  logic [W-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (clr)          mask_q <= '1;
    else if (wr_mask) mask_q <= wdata;
    else if (wr_clr)  mask_q <= mask_q & ~wdata;
    else if (wr_set)  mask_q <= mask_q | wdata;
  end

  assign mask = mask_q;
  assign pend = src & ~mask_q;

  // R2: ones written to the clear alias leave those lines unmasked
  a_r2_clear_alias: assert property (@(posedge clk) disable iff (rst)
    (wr_clr && !clr) |=> ((mask & $past(wdata)) == '0));
  // R2: ones written to the set alias leave those lines masked
  a_r2_set_alias: assert property (@(posedge clk) disable iff (rst)
    (wr_set && !clr) |=> ((mask & $past(wdata)) == $past(wdata)));
endmodule

// File: rtl/intc_level_regs.sv
module intc_level_regs #(
  parameter int N  = 96,
  parameter int PW = 6,
  parameter int IW = 7
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [PW-1:0] wpri,
  input  logic [IW-1:0] ridx,
  output logic [PW-1:0] rpri,
  output logic [N*PW-1:0] pri_flat
);
  for (genvar i = 0; i < N; i++) begin : g_line
    logic [PW-1:0] p_q;
    always_ff @(posedge clk) begin
      if (clr)                           p_q <= '0;
      else if (we && widx == IW'(i))     p_q <= wpri;
    end
    assign pri_flat[i*PW +: PW] = p_q;
  end

  always_comb begin
    rpri = '0;
    for (int i = 0; i < N; i++)
      if (ridx == IW'(i)) rpri = pri_flat[i*PW +: PW];
  end
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
  parameter int N  = 96,
  parameter int PW = 6,
  parameter int IW = 7
) (
  input  logic [N-1:0]    elig,
  input  logic [N*PW-1:0] pri_flat,
  output logic            found,
  output logic [IW-1:0]   win_id,
  output logic [PW-1:0]   win_pri
);
  // ascending scan; strict compare keeps the lower number on a tie
  always_comb begin
    found   = 1'b0;
    win_id  = '0;
    win_pri = '1;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && (!found || pri_flat[i*PW +: PW] < win_pri)) begin
        found   = 1'b1;
        win_id  = IW'(i);
        win_pri = pri_flat[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
#(
  parameter int         NUM_SRC   = 96,
  parameter int         PRI_W     = 6,
  parameter int         RST_CYC   = 4,
  parameter logic [3:0] REV_MAJOR = 4'h5,
  parameter logic [3:0] REV_MINOR = 4'h0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [REG_AW-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [REG_DW-1:0]  bus_wdata,
  output logic [REG_DW-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] src_lvl,
  output logic               irq
);
  localparam int NUM_BANKS = NUM_SRC / BANK_W;
  localparam int ID_W      = $clog2(NUM_SRC);
  localparam int CW        = $clog2(RST_CYC + 1);

  // soft reset window
  logic [CW-1:0] rst_cnt;
  logic          busy, wr_ok, sr_req, clr_all, ack_wr;

  assign busy    = (rst_cnt != '0);
  assign wr_ok   = bus_we && !busy;
  assign sr_req  = wr_ok && (bus_addr == OFS_CFG) && bus_wdata[1];
  assign clr_all = rst || sr_req || busy;
  assign ack_wr  = wr_ok && (bus_addr == OFS_CTRL) && bus_wdata[0];

  always_ff @(posedge clk) begin
    if (rst || sr_req) rst_cnt <= CW'(RST_CYC);
    else if (busy)     rst_cnt <= rst_cnt - 1'b1;
  end

  // plain control registers
  logic             autoidle_q, prot_q;
  logic [1:0]       idle_q;
  logic [THR_W-1:0] thr_q;

  always_ff @(posedge clk) begin
    if (clr_all) begin
      autoidle_q <= 1'b0;
      prot_q     <= 1'b0;
      idle_q     <= 2'b00;
      thr_q      <= '1;
    end else if (wr_ok) begin
      if (bus_addr == OFS_CFG)  autoidle_q <= bus_wdata[0];
      if (bus_addr == OFS_PROT) prot_q     <= bus_wdata[0];
      if (bus_addr == OFS_IDLE) idle_q     <= bus_wdata[1:0];
      if (bus_addr == OFS_THR)  thr_q      <= bus_wdata[THR_W-1:0];
    end
  end

  // mask banks
  logic [NUM_BANKS-1:0][BANK_W-1:0] mask_bk, pend_bk;
  logic [NUM_SRC-1:0]               pend_flat;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [REG_AW-1:0] A_MASK = bank_ofs(OFS_MASK, b);
    localparam logic [REG_AW-1:0] A_MCLR = bank_ofs(OFS_MCLR, b);
    localparam logic [REG_AW-1:0] A_MSET = bank_ofs(OFS_MSET, b);
    intc_mask_bank #(.W(BANK_W)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .clr     (clr_all),
      .wr_mask (wr_ok && bus_addr == A_MASK),
      .wr_clr  (wr_ok && bus_addr == A_MCLR),
      .wr_set  (wr_ok && bus_addr == A_MSET),
      .wdata   (bus_wdata[BANK_W-1:0]),
      .src     (src_lvl[b*BANK_W +: BANK_W]),
      .mask    (mask_bk[b]),
      .pend    (pend_bk[b])
    );
  end
  assign pend_flat = pend_bk;

  // level registers
  logic [REG_AW-1:0]        lvl_off;
  logic                     lvl_hit;
  logic [ID_W-1:0]          lvl_idx;
  logic [PRI_W-1:0]         lvl_rpri;
  logic [NUM_SRC*PRI_W-1:0] pri_flat;

  assign lvl_off = bus_addr - OFS_LVL;
  assign lvl_hit = (bus_addr >= OFS_LVL) && (lvl_off[1:0] == 2'b00) &&
                   (lvl_off[REG_AW-1:2] < (REG_AW-2)'(NUM_SRC));
  assign lvl_idx = lvl_off[ID_W+1:2];

  intc_level_regs #(.N(NUM_SRC), .PW(PRI_W), .IW(ID_W)) u_lvl (
    .clk      (clk),
    .clr      (clr_all),
    .we       (wr_ok && lvl_hit),
    .widx     (lvl_idx),
    .wpri     (bus_wdata[PRI_W+1:2]),
    .ridx     (lvl_idx),
    .rpri     (lvl_rpri),
    .pri_flat (pri_flat)
  );

  // eligibility: unmasked, asserted, below threshold unless disabled
  logic [NUM_SRC-1:0] elig;
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_elig
    assign elig[i] = pend_flat[i] &&
                     ((thr_q == '1) || (THR_W'(pri_flat[i*PRI_W +: PRI_W]) < thr_q));
  end

  logic             found;
  logic [ID_W-1:0]  win_id;
  logic [PRI_W-1:0] win_pri;

  intc_arbiter #(.N(NUM_SRC), .PW(PRI_W), .IW(ID_W)) u_arb (
    .elig     (elig),
    .pri_flat (pri_flat),
    .found    (found),
    .win_id   (win_id),
    .win_pri  (win_pri)
  );

  // active latch
  logic             irq_q;
  logic [ID_W-1:0]  act_q;
  logic [PRI_W-1:0] act_pri_q;

  always_ff @(posedge clk) begin
    if (clr_all) begin
      irq_q     <= 1'b0;
      act_q     <= '0;
      act_pri_q <= '0;
    end else if (ack_wr) begin
      irq_q <= 1'b0;
    end else if (!irq_q && found) begin
      irq_q     <= 1'b1;
      act_q     <= win_id;
      act_pri_q <= win_pri;
    end
  end
  assign irq = irq_q;

  // read path
  logic [REG_DW-1:0] rd_val, rdata_q;

  always_comb begin
    rd_val = '0;
    case (bus_addr)
      OFS_REV:  rd_val = REG_DW'({REV_MAJOR, REV_MINOR});
      OFS_CFG:  rd_val = REG_DW'(autoidle_q);
      OFS_STAT: rd_val = REG_DW'(!busy);
      OFS_ACT:  rd_val = REG_DW'(act_q);
      OFS_PROT: rd_val = REG_DW'(prot_q);
      OFS_IDLE: rd_val = REG_DW'(idle_q);
      OFS_THR:  rd_val = REG_DW'(thr_q);
      default:  rd_val = '0;
    endcase
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bus_addr == bank_ofs(OFS_MASK, b)) rd_val = mask_bk[b];
      if (bus_addr == bank_ofs(OFS_PEND, b)) rd_val = pend_bk[b];
    end
    if (lvl_hit) rd_val = REG_DW'({lvl_rpri, 2'b00});
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_val;
  end
  assign bus_rdata = rdata_q;

  // R7: an acknowledge write drops the request at that edge
  a_r7_ack_drops_irq: assert property (@(posedge clk) disable iff (rst)
    ack_wr |=> !irq_q);
  // R6: an active interrupt and its number hold until acknowledged
  a_r6_active_frozen: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !ack_wr && !clr_all) |=> (irq_q && $stable(act_q)));
  // R8: a soft-reset request opens the not-done window
  a_r8_busy_after_request: assert property (@(posedge clk) disable iff (rst)
    sr_req |=> (busy && !irq_q));
  // R5: a newly raised interrupt passed the threshold in force before the edge
  a_r5_below_threshold: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> (($past(thr_q) == '1) || (THR_W'(act_pri_q) < $past(thr_q))));
endmodule

// File: tb/tb_prio_intc.sv
module tb_prio_intc;
  localparam int N = 96;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N-1:0] src_lvl = '0;
  logic        irq;

  always #5 clk = ~clk;

  prio_intc #(.NUM_SRC(N)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_lvl(src_lvl), .irq(irq)
  );

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t exp_q[$];
  int    checks = 0;
  int    errors = 0;
  logic  rd_req = 1'b0;
  logic  fetch  = 1'b0;

  // monitor: compares registered read data one edge after each request
  always @(posedge clk) fetch <= rd_req;
  always @(negedge clk) begin
    if (fetch) begin
      item_t it;
      it = exp_q.pop_front();
      checks++;
      if (bus_rdata !== it.exp) begin
        errors++;
        $display("FAIL %s: rdata %h expected %h", it.tag, bus_rdata, it.exp);
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    exp_q.push_back(it);
    bus_addr = a; rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s: irq %b expected %b", tag, irq, e);
    end
  endtask

  function automatic logic [11:0] lvl(input int n);
    return 12'h100 + 12'(4 * n);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run still going, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    rd(12'h014, 32'h0, "R8 status during reset window");
    chk_irq(1'b0, "R1 irq after reset");
    repeat (8) @(negedge clk);
    rd(12'h014, 32'h1, "R8 status done");
    rd(12'h084, 32'hFFFF_FFFF, "R1 mask bank0");
    rd(12'h0A4, 32'hFFFF_FFFF, "R1 mask bank1");
    rd(12'h0C4, 32'hFFFF_FFFF, "R1 mask bank2");
    rd(12'h068, 32'hFF, "R1 threshold");
    rd(12'h040, 32'h0, "R1 active");
    rd(12'h000, 32'h50, "R10 revision");
    rd(12'h020, 32'h0, "R12 unmapped");
    rd(12'h010, 32'h0, "R9 config reset");

    // priorities: lines 2,5 -> 10 ; lines 40,70 -> 3
    wr(lvl(5), 32'h28);
    wr(lvl(2), 32'h28);
    wr(lvl(40), 32'h0C);
    wr(lvl(70), 32'h0C);
    wr(lvl(1), 32'hFFFF_FFFF);
    rd(lvl(40), 32'h0C, "R11 level readback");
    rd(lvl(1), 32'hFC, "R11 level other bits zero");

    // mask aliases
    wr(12'h088, 32'h24);
    rd(12'h084, 32'hFFFF_FFDB, "R2 clear alias");
    wr(12'h08C, 32'h0);
    rd(12'h084, 32'hFFFF_FFDB, "R2 zero write to set alias");
    wr(12'h08C, 32'h20);
    rd(12'h084, 32'hFFFF_FFFB, "R2 set alias");
    wr(12'h088, 32'h20);
    rd(12'h084, 32'hFFFF_FFDB, "R2 clear alias again");

    // tie between lines 2 and 5; line 7 masked
    src_lvl[2] = 1'b1; src_lvl[5] = 1'b1; src_lvl[7] = 1'b1;
    @(negedge clk);
    chk_irq(1'b1, "R6 irq raised");
    rd(12'h040, 32'd2, "R4 tie goes to lower number");
    rd(12'h098, 32'h24, "R3 pending bank0");

    // frozen while active
    wr(12'h0A8, 32'h100);
    wr(12'h0C8, 32'h40);
    src_lvl[40] = 1'b1; src_lvl[70] = 1'b1; src_lvl[2] = 1'b0;
    @(negedge clk);
    rd(12'h040, 32'd2, "R6 active frozen");
    chk_irq(1'b1, "R6 irq held after source drop");
    rd(12'h0B8, 32'h100, "R3 pending bank1");

    // acknowledge
    wr(12'h048, 32'h0);
    chk_irq(1'b1, "R7 write without bit0 ignored");
    wr(12'h048, 32'h1);
    chk_irq(1'b0, "R7 ack drops irq");
    @(negedge clk);
    chk_irq(1'b1, "R7 next winner presented");
    rd(12'h040, 32'd40, "R4 most urgent, lower number on tie");

    // threshold equal to pending priority blocks
    wr(12'h068, 32'd3);
    wr(12'h048, 32'h1);
    chk_irq(1'b0, "R5 ack under threshold");
    repeat (3) @(negedge clk);
    chk_irq(1'b0, "R5 priority equal to threshold blocked");
    rd(12'h068, 32'd3, "R5 threshold readback");
    wr(12'h068, 32'd4);
    @(negedge clk);
    chk_irq(1'b1, "R5 priority below threshold admitted");
    rd(12'h040, 32'd40, "R5 active under threshold");

    src_lvl[40] = 1'b0;
    wr(12'h048, 32'h1);
    @(negedge clk);
    chk_irq(1'b1, "R4 next line");
    rd(12'h040, 32'd70, "R4 line 70 after 40 released");

    wr(12'h068, 32'hFF);
    src_lvl[70] = 1'b0;
    wr(12'h048, 32'h1);
    @(negedge clk);
    rd(12'h040, 32'd5, "R5 threshold 0xFF admits all");

    // plain registers
    wr(12'h010, 32'h1);
    rd(12'h010, 32'h1, "R9 autoidle");
    wr(12'h04C, 32'hFFFF_FFFF);
    rd(12'h04C, 32'h1, "R9 protection");
    wr(12'h050, 32'hFFFF_FFFF);
    rd(12'h050, 32'h3, "R9 idle");

    // soft reset
    wr(12'h010, 32'h2);
    rd(12'h014, 32'h0, "R8 status not done");
    wr(12'h068, 32'h5);
    repeat (6) @(negedge clk);
    rd(12'h014, 32'h1, "R8 status done again");
    rd(12'h068, 32'hFF, "R8 write in window ignored");
    rd(12'h010, 32'h0, "R8 config cleared");
    rd(12'h084, 32'hFFFF_FFFF, "R8 mask restored");
    rd(lvl(5), 32'h0, "R8 level cleared");
    chk_irq(1'b0, "R8 irq low after soft reset");

    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule